// File: doc/BRIEF.md
# Interrupt and Exception Prioritizer

This block gathers the pending events competing for the processor's attention and decides which one is serviced at each instruction boundary. The candidates are instruction faults, the single-step trap, the non-maskable interrupt, a coprocessor segment overrun, the maskable external interrupt and software interrupt requests. For each chosen event it produces a registered acknowledge pulse together with the vector number and a source code. The sequencer uses these to run the service routine.

The block also tracks the halted state. A halt request parks the core. Boundary strobes are then ignored until a non-maskable interrupt or an enabled external interrupt arrives. That event is acknowledged in the same cycle that the halted state ends, so execution carries on with the instruction that follows the halt. Table lookups, stack frames and bus acknowledge cycles are left to other blocks.

Top module: `exc_prioritizer`

## Requirements
- R1: While rst_ni is low, ack_o, halted_o, src_o and vec_o are all 0, whatever the other inputs do.
- R2: Outside the halted state, an event is chosen only on a clock edge where boundary_i is high. At most one event is acknowledged per strobe. ack_o is high for exactly the one cycle after that edge, and vec_o and src_o are valid in that cycle. Source codes are: 0 none, 1 fault, 2 step, 3 NMI, 4 segment overrun, 5 INTR, 6 software INT.
- R3: When several events are pending, the one served is picked in this order, highest first: fault, single step, NMI, segment overrun, INTR, software INT. Requests that lose stay pending for later strobes.
- R4: fault_i bit 0 (divide error) gives vector 0, bit 1 (breakpoint) gives vector 3, bit 2 (bound range) gives vector 5 and bit 3 (invalid opcode) gives vector 6. When several bits are set, the lowest set bit wins.
- R5: The single-step event (vector 1) is raised at a boundary only while trap_flag_i is high.
- R6: The NMI (vector 2) is latched on a rising edge of nmi_i and acknowledged once per edge. It ignores if_flag_i.
- R7: After an NMI is acknowledged, further NMIs are held off until an iret_i pulse. An edge that arrives in that window is kept pending and is served after the pulse.
- R8: INTR is served only while if_flag_i is high, and its vector is intr_vec_i.
- R9: A software INT uses soft_vec_i as its vector. A segment overrun uses the SEG_OVR_VEC parameter.
- R10: A halt_i pulse sets halted_o on the next edge. While halted, boundary strobes, faults, step, segment overrun and software INT requests produce no acknowledge.
- R11: While halted, a pending NMI or an enabled INTR is acknowledged and clears halted_o on the same edge. A masked INTR does not end the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| fault_i | input | 4 | Instruction fault requests |
| trap_flag_i | input | 1 | Single-step trap flag |
| nmi_i | input | 1 | Non-maskable interrupt line |
| iret_i | input | 1 | Return-from-interrupt pulse |
| seg_ovr_i | input | 1 | Coprocessor segment overrun request |
| intr_i | input | 1 | Maskable interrupt request |
| if_flag_i | input | 1 | Interrupt-enable flag |
| intr_vec_i | input | VEC_W | Vector supplied with INTR |
| soft_int_i | input | 1 | Software interrupt request |
| soft_vec_i | input | VEC_W | Immediate vector of the software interrupt |
| halt_i | input | 1 | Halt instruction executed |
| ack_o | output | 1 | Acknowledge pulse |
| vec_o | output | VEC_W | Vector of the acknowledged event |
| src_o | output | 3 | Source class of the acknowledged event |
| halted_o | output | 1 | Core is halted |

## Verification
The bench builds the block with VEC_W at its default of 8 and SEG_OVR_VEC set to 13. The non-default overrun vector makes that source distinguishable from every fixed fault or trap vector. With 8-bit vectors, external and software vectors across the byte range (0x40, 0x55, 0x80) can be checked against the pass-through requirement. The scenarios run every level of the priority ladder in a single drain sequence. They also cover the NMI hold-off window, including an edge that arrives while blocked, and halt entry, ignored events, masked INTR and both wake-up paths.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int FAULT_N = 4;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_FAULT  = 3'd1,
    SRC_STEP   = 3'd2,
    SRC_NMI    = 3'd3,
    SRC_SEGOVR = 3'd4,
    SRC_INTR   = 3'd5,
    SRC_SOFT   = 3'd6
  } src_e;

  localparam logic [7:0] STEP_VEC = 8'd1;
  localparam logic [7:0] NMI_VEC  = 8'd2;

  // fault bit index -> architectural vector
  function automatic logic [7:0] fault_vec(input int idx);
    case (idx)
      0:       return 8'd0;
      1:       return 8'd3;
      2:       return 8'd5;
      default: return 8'd6;
    endcase
  endfunction
endpackage

// File: rtl/exc_nmi_gate.sv
module exc_nmi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  input  logic iret_i,
  output logic ok_o
);
  logic nmi_q, pend_q, blk_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;
  assign ok_o = (pend_q | rise) & ~blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= (pend_q | rise) & ~take_i;
      if (take_i)      blk_q <= 1'b1;
      else if (iret_i) blk_q <= 1'b0;
    end
  end

  p_nmi_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q && !iret_i |=> blk_q);

  p_nmi_take_unblocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !blk_q);
endmodule

// File: rtl/exc_halt_fsm.sv
module exc_halt_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic wake_i,
  output logic halted_o
);
  typedef enum logic {ST_RUN, ST_HALT} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (halt_i) st_d = ST_HALT;
      ST_HALT: if (wake_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign halted_o = (st_q == ST_HALT);

  p_halt_stay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !wake_i |=> halted_o);

  p_halt_enter_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o && halt_i |=> halted_o);
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int              VEC_W       = 8,
  parameter logic [VEC_W-1:0] SEG_OVR_VEC = VEC_W'(9)
) (
  input  logic               go_i,
  input  logic               halted_i,
  input  logic [FAULT_N-1:0] fault_i,
  input  logic               trap_i,
  input  logic               nmi_ok_i,
  input  logic               seg_i,
  input  logic               intr_i,
  input  logic               if_i,
  input  logic [VEC_W-1:0]   intr_vec_i,
  input  logic               soft_i,
  input  logic [VEC_W-1:0]   soft_vec_i,
  output logic               take_o,
  output logic               nmi_take_o,
  output src_e               src_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [VEC_W-1:0] fvec [FAULT_N];

  for (genvar g = 0; g < FAULT_N; g++) begin : g_fvec
    assign fvec[g] = VEC_W'(fault_vec(g));
  end

  logic [VEC_W-1:0] fault_sel;
  always_comb begin
    fault_sel = '0;
    for (int i = FAULT_N - 1; i >= 0; i--) begin
      if (fault_i[i]) fault_sel = fvec[i];
    end
  end

  logic intr_ok;
  assign intr_ok = intr_i & if_i;

  always_comb begin
    src_o = SRC_NONE;
    vec_o = '0;
    if (go_i) begin
      if (halted_i) begin
        // only wake sources count while parked
        if (nmi_ok_i) begin
          src_o = SRC_NMI;  vec_o = VEC_W'(NMI_VEC);
        end else if (intr_ok) begin
          src_o = SRC_INTR; vec_o = intr_vec_i;
        end
      end else if (|fault_i) begin
        src_o = SRC_FAULT;  vec_o = fault_sel;
      end else if (trap_i) begin
        src_o = SRC_STEP;   vec_o = VEC_W'(STEP_VEC);
      end else if (nmi_ok_i) begin
        src_o = SRC_NMI;    vec_o = VEC_W'(NMI_VEC);
      end else if (seg_i) begin
        src_o = SRC_SEGOVR; vec_o = SEG_OVR_VEC;
      end else if (intr_ok) begin
        src_o = SRC_INTR;   vec_o = intr_vec_i;
      end else if (soft_i) begin
        src_o = SRC_SOFT;   vec_o = soft_vec_i;
      end
    end
  end

  assign take_o     = (src_o != SRC_NONE);
  assign nmi_take_o = (src_o == SRC_NMI);
endmodule

// File: rtl/exc_prioritizer.sv
module exc_prioritizer
  import exc_pkg::*;
#(
  parameter int              VEC_W       = 8,
  parameter logic [VEC_W-1:0] SEG_OVR_VEC = VEC_W'(9)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boundary_i,
  input  logic [FAULT_N-1:0] fault_i,
  input  logic               trap_flag_i,
  input  logic               nmi_i,
  input  logic               iret_i,
  input  logic               seg_ovr_i,
  input  logic               intr_i,
  input  logic               if_flag_i,
  input  logic [VEC_W-1:0]   intr_vec_i,
  input  logic               soft_int_i,
  input  logic [VEC_W-1:0]   soft_vec_i,
  input  logic               halt_i,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [2:0]         src_o,
  output logic               halted_o
);
  logic             nmi_ok, nmi_take, take, halted;
  src_e             src_d, src_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic             ack_q;

  exc_nmi_gate u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_i (nmi_i),
    .take_i(nmi_take),
    .iret_i(iret_i),
    .ok_o  (nmi_ok)
  );

  exc_pick #(.VEC_W(VEC_W), .SEG_OVR_VEC(SEG_OVR_VEC)) u_pick (
    .go_i      (boundary_i | halted),
    .halted_i  (halted),
    .fault_i   (fault_i),
    .trap_i    (trap_flag_i),
    .nmi_ok_i  (nmi_ok),
    .seg_i     (seg_ovr_i),
    .intr_i    (intr_i),
    .if_i      (if_flag_i),
    .intr_vec_i(intr_vec_i),
    .soft_i    (soft_int_i),
    .soft_vec_i(soft_vec_i),
    .take_o    (take),
    .nmi_take_o(nmi_take),
    .src_o     (src_d),
    .vec_o     (vec_d)
  );

  exc_halt_fsm u_halt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .halt_i  (halt_i),
    .wake_i  (take),
    .halted_o(halted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      src_q <= SRC_NONE;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      if (take) begin
        src_q <= src_d;
        vec_q <= vec_d;
      end
    end
  end

  assign ack_o    = ack_q;
  assign src_o    = src_q;
  assign vec_o    = vec_q;
  assign halted_o = halted;

  p_ack_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(boundary_i || halted_o));

  p_step_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && src_o == SRC_STEP |-> $past(trap_flag_i) && vec_o == VEC_W'(1));

  p_intr_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && src_o == SRC_INTR |-> $past(if_flag_i));

  p_fault_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && src_o == SRC_FAULT |->
      (vec_o == VEC_W'(0) || vec_o == VEC_W'(3) || vec_o == VEC_W'(5) || vec_o == VEC_W'(6)));

  p_wake_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> ack_o && (src_o == SRC_NMI || src_o == SRC_INTR));
endmodule

// File: tb/exc_prioritizer_test.sv
module exc_prioritizer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boundary_i = 1'b0;
  logic [3:0] fault_i = '0;
  logic       trap_flag_i = 1'b0, nmi_i = 1'b0, iret_i = 1'b0, seg_ovr_i = 1'b0;
  logic       intr_i = 1'b0, if_flag_i = 1'b0, soft_int_i = 1'b0, halt_i = 1'b0;
  logic [7:0] intr_vec_i = '0, soft_vec_i = '0;
  logic       ack_o, halted_o;
  logic [7:0] vec_o;
  logic [2:0] src_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  exc_prioritizer #(.VEC_W(8), .SEG_OVR_VEC(8'd13)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary_i), .fault_i(fault_i),
    .trap_flag_i(trap_flag_i), .nmi_i(nmi_i), .iret_i(iret_i), .seg_ovr_i(seg_ovr_i),
    .intr_i(intr_i), .if_flag_i(if_flag_i), .intr_vec_i(intr_vec_i),
    .soft_int_i(soft_int_i), .soft_vec_i(soft_vec_i), .halt_i(halt_i),
    .ack_o(ack_o), .vec_o(vec_o), .src_o(src_o), .halted_o(halted_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one boundary strobe; returns at the following negedge, outputs valid
  task automatic strobe();
    @(negedge clk) boundary_i = 1'b1;
    @(negedge clk) boundary_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ack(input string rq, input int src, input int vec);
    chk({rq, " ack"}, ack_o, 1);
    chk({rq, " src"}, src_o, src);
    chk({rq, " vec"}, vec_o, vec);
  endtask

  task automatic pulse_iret();
    @(negedge clk) iret_i = 1'b1;
    @(negedge clk) iret_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ack", ack_o, 0); chk("R1 halted", halted_o, 0);
    chk("R1 src", src_o, 0); chk("R1 vec", vec_o, 0);
    idle(2); rst_ni = 1'b1; idle(1);
  endtask

  task automatic t_boundary();
    intr_i = 1; if_flag_i = 1; intr_vec_i = 8'h40;
    idle(3);
    chk("R2 no strobe no ack", ack_o, 0);
    strobe();
    expect_ack("R2", 5, 8'h40);
    idle(1);
    chk("R2 single cycle pulse", ack_o, 0);
    intr_i = 0;
  endtask

  task automatic t_priority();
    fault_i = 4'b0100; trap_flag_i = 1; nmi_i = 1; seg_ovr_i = 1;
    intr_i = 1; intr_vec_i = 8'h41; soft_int_i = 1; soft_vec_i = 8'h80;
    strobe(); expect_ack("R3 fault first", 1, 5);
    fault_i = 0;
    strobe(); expect_ack("R3 step second", 2, 1);
    trap_flag_i = 0;
    strobe(); expect_ack("R3 nmi third", 3, 2);
    strobe(); expect_ack("R9 segment overrun", 4, 13);
    seg_ovr_i = 0;
    strobe(); expect_ack("R3 intr fifth", 5, 8'h41);
    intr_i = 0;
    strobe(); expect_ack("R9 soft int", 6, 8'h80);
    soft_int_i = 0;
    strobe(); chk("R6 held nmi not repeated", ack_o, 0);
    nmi_i = 0;
  endtask

  task automatic t_faults();
    fault_i = 4'b1010; strobe(); expect_ack("R4 breakpoint wins", 1, 3);
    fault_i = 4'b1000; strobe(); expect_ack("R4 invalid opcode", 1, 6);
    fault_i = 4'b0001; strobe(); expect_ack("R4 divide", 1, 0);
    fault_i = 4'b0000;
  endtask

  task automatic t_step();
    trap_flag_i = 0; strobe(); chk("R5 no trap flag", ack_o, 0);
    trap_flag_i = 1; strobe(); expect_ack("R5 step", 2, 1);
    trap_flag_i = 0;
  endtask

  task automatic t_nmi();
    if_flag_i = 0;
    nmi_i = 1; idle(1);
    strobe(); chk("R7 blocked before iret", ack_o, 0);
    pulse_iret();
    strobe(); expect_ack("R6 nmi with if clear", 3, 2);
    strobe(); chk("R6 one ack per edge", ack_o, 0);
    nmi_i = 0;
    pulse_iret();
  endtask

  task automatic t_intr();
    if_flag_i = 0; intr_i = 1; intr_vec_i = 8'h55;
    strobe(); chk("R8 masked intr", ack_o, 0);
    if_flag_i = 1;
    strobe(); expect_ack("R8 enabled intr", 5, 8'h55);
    intr_i = 0;
  endtask

  task automatic t_halt_nmi();
    halt_i = 1; @(negedge clk) halt_i = 0;
    chk("R10 halted set", halted_o, 1);
    fault_i = 4'b0001; soft_int_i = 1; trap_flag_i = 1; seg_ovr_i = 1;
    strobe();
    chk("R10 strobe ignored", ack_o, 0);
    chk("R10 still halted", halted_o, 1);
    if_flag_i = 0; intr_i = 1; idle(2);
    chk("R11 masked intr no wake ack", ack_o, 0);
    chk("R11 masked intr stays halted", halted_o, 1);
    nmi_i = 1; idle(1);
    expect_ack("R11 nmi wake", 3, 2);
    chk("R11 nmi clears halt", halted_o, 0);
    fault_i = 0; soft_int_i = 0; trap_flag_i = 0; seg_ovr_i = 0;
    intr_i = 0; nmi_i = 0;
    pulse_iret();
  endtask

  task automatic t_halt_intr();
    halt_i = 1; @(negedge clk) halt_i = 0;
    chk("R10 halted again", halted_o, 1);
    if_flag_i = 1; intr_i = 1; intr_vec_i = 8'h66; idle(1);
    expect_ack("R11 intr wake", 5, 8'h66);
    chk("R11 intr clears halt", halted_o, 0);
    intr_i = 0;
  endtask

  task automatic t_reset_mid();
    halt_i = 1; @(negedge clk) halt_i = 0;
    rst_ni = 0; #1;
    chk("R1 reset clears halt", halted_o, 0);
    boundary_i = 1; intr_i = 1; if_flag_i = 1; idle(2);
    chk("R1 no ack in reset", ack_o, 0);
    chk("R1 src in reset", src_o, 0);
    boundary_i = 0; intr_i = 0; rst_ni = 1; idle(1);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_priority();
    t_faults();
    t_step();
    t_nmi();
    t_intr();
    t_halt_nmi();
    t_halt_intr();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule